// File: doc/BRIEF.md
# Self-Clearing Signed Multiply-Accumulator

This block multiplies two signed operands and sums the products into a wide accumulator. The operands have independent widths. A parameter fixes the group length, which is the number of products in each sum. When the last product of a group has been added, the block raises a one-cycle result strobe and presents the sum. The next qualified product then starts a new sum from zero. No clear input exists.

A valid qualifier marks each operand pair. Cycles with the qualifier low add nothing and do not advance the group count. The accumulator is sized so that a full group of worst-case products cannot overflow. The presented result may be narrower than the accumulator, in which case only its most significant bits are kept.

The datapath has three register stages: an operand stage, a product stage and the accumulator. A new operand pair can enter on every cycle.

Top module: `sc_macc`

## Requirements
- R1: When `in_valid` is high on a rising edge, the two's-complement product `in_a * in_b` is added to the running sum of the current group. The presented result is exactly that sum, truncated as R6 describes.
- R2: `out_valid` is high for exactly one cycle per group. It rises on the third rising edge counted from the edge that samples the group's last qualified pair, the sampling edge being the first, so `in_valid` sampled three edges earlier was high. When ACC_N > 1 it is never high on two consecutive cycles.
- R3: Each group's sum starts from zero. The first product of a group is loaded rather than added to the previous total.
- R4: Qualified pairs arriving on consecutive cycles form consecutive groups with no lost cycle. The result strobes are then exactly ACC_N cycles apart.
- R5: A cycle with `in_valid` low changes neither the group count nor the sum, whatever values `in_a` and `in_b` carry.
- R6: `out_data` holds bits [ACC_W-1 : ACC_W-OUT_W] of the accumulator, and is the full accumulator when OUT_W equals ACC_W.
- R7: ACC_W = A_W + B_W + ceil(log2(ACC_N)). A full group of the most negative operands, or of the most negative operand times the most positive one, sums without overflow.
- R8: With ACC_N = 1, every qualified pair gives its own result equal to the single product.
- R9: A synchronous `rst` clears the accumulator, the group count, the pipeline and `out_valid`. A partially collected group is discarded, and the first group after reset starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_a`/`in_b` on this edge |
| in_a | input | A_W | Signed multiplicand |
| in_b | input | B_W | Signed multiplier |
| out_valid | output | 1 | One-cycle strobe: group result present |
| out_data | output | OUT_W | Signed group sum, most significant OUT_W bits of the accumulator |

## Verification
Two events can fall in the same cycle: one group closing and the next group's first product loading. When qualified pairs stream with no gap, the result strobe of one group is raised on the same edge that the next group's first pair is captured. One edge later the accumulator overwrites the finished sum with the new product instead of adding to it. The bench provokes this with ten back-to-back qualified pairs. It judges the result by the strobe spacing being exactly ACC_N cycles, and by each reported sum matching a model in which every group starts fresh. A reset that lands in the middle of a group is also checked, to confirm that none of the discarded partial sum leaks into the next result.

// File: rtl/sc_macc_pkg.sv
package sc_macc_pkg;

  // Accumulator width: full product plus headroom for the group length
  function automatic int acc_width(input int aw, input int bw, input int n);
    return aw + bw + ((n > 1) ? $clog2(n) : 0);
  endfunction

  // Group counter width, never below one bit
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of accumulator LSBs dropped on the way to the output
  function automatic int drop_bits(input int accw, input int outw);
    return (accw > outw) ? (accw - outw) : 0;
  endfunction

endpackage

// File: rtl/sc_macc_count.sv
module sc_macc_count #(
  parameter int GRP_N = 5,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          grp_first,
  output logic          grp_last
);

  logic [CW-1:0] cnt_q;

  assign grp_first = (cnt_q == '0);
  assign grp_last  = (cnt_q == CW'(GRP_N - 1));
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= grp_last ? '0 : cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/sc_macc_mult.sv
module sc_macc_mult #(
  parameter int A_W = 16,
  parameter int B_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [A_W-1:0]   in_a,
  input  logic signed [B_W-1:0]   in_b,
  input  logic                    in_first,
  input  logic                    in_last,
  output logic                    p_vld,
  output logic signed [A_W+B_W-1:0] p_data,
  output logic                    p_first,
  output logic                    p_last
);

  localparam int PW = A_W + B_W;

  logic                  s1_vld, s1_first, s1_last;
  logic signed [A_W-1:0] s1_a;
  logic signed [B_W-1:0] s1_b;
  logic signed [PW-1:0]  a_ext, b_ext, prod_d;

  assign a_ext  = PW'(s1_a);
  assign b_ext  = PW'(s1_b);
  assign prod_d = a_ext * b_ext;

  // Stage 1: operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_vld   <= in_vld;
      s1_first <= in_first;
      s1_last  <= in_last;
      s1_a     <= in_a;
      s1_b     <= in_b;
    end
  end

  // Stage 2: full-width product
  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld   <= 1'b0;
      p_first <= 1'b0;
      p_last  <= 1'b0;
      p_data  <= '0;
    end else begin
      p_vld   <= s1_vld;
      p_first <= s1_first;
      p_last  <= s1_last;
      p_data  <= prod_d;
    end
  end

endmodule

// File: rtl/sc_macc_accum.sv
module sc_macc_accum #(
  parameter int PW    = 28,
  parameter int ACC_W = 31,
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    p_vld,
  input  logic signed [PW-1:0]    p_data,
  input  logic                    p_first,
  input  logic                    p_last,
  output logic signed [ACC_W-1:0] acc,
  output logic                    res_vld,
  output logic [OUT_W-1:0]        res_data
);

  logic signed [ACC_W-1:0] p_ext, acc_q;

  assign p_ext = ACC_W'(p_data);
  assign acc   = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= p_vld && p_last;
      if (p_vld) begin
        acc_q <= p_first ? p_ext : acc_q + p_ext;
      end
    end
  end

  generate
    if (OUT_W >= ACC_W) begin : g_full
      assign res_data = OUT_W'(acc_q);
    end else begin : g_trunc
      assign res_data = acc_q[ACC_W-1 -: OUT_W];
    end
  endgenerate

endmodule

// File: rtl/sc_macc.sv
module sc_macc
  import sc_macc_pkg::*;
#(
  parameter int A_W   = 16,
  parameter int B_W   = 12,
  parameter int ACC_N = 5,
  parameter int OUT_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [A_W-1:0] in_a,
  input  logic signed [B_W-1:0] in_b,
  output logic                  out_valid,
  output logic [OUT_W-1:0]      out_data
);

  localparam int PROD_W = A_W + B_W;
  localparam int ACC_W  = acc_width(A_W, B_W, ACC_N);
  localparam int CNT_W  = cnt_width(ACC_N);

  // Named internal events, observed by the bound checker
  logic [CNT_W-1:0]        grp_cnt;
  logic                    grp_first, grp_last;
  logic                    prod_vld, prod_first, prod_last;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0] acc_q;

  sc_macc_count #(.GRP_N(ACC_N), .CW(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .adv       (in_valid),
    .cnt       (grp_cnt),
    .grp_first (grp_first),
    .grp_last  (grp_last)
  );

  sc_macc_mult #(.A_W(A_W), .B_W(B_W)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_valid),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_first (grp_first),
    .in_last  (grp_last),
    .p_vld    (prod_vld),
    .p_data   (prod),
    .p_first  (prod_first),
    .p_last   (prod_last)
  );

  sc_macc_accum #(.PW(PROD_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .p_vld    (prod_vld),
    .p_data   (prod),
    .p_first  (prod_first),
    .p_last   (prod_last),
    .acc      (acc_q),
    .res_vld  (out_valid),
    .res_data (out_data)
  );

endmodule

// File: rtl/sc_macc_chk.sv
module sc_macc_chk #(
  parameter int N  = 5,
  parameter int CW = 3,
  parameter int AW = 31
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [CW-1:0]        cnt,
  input logic                 p_vld,
  input logic                 p_last,
  input logic signed [AW-1:0] acc,
  input logic                 out_valid
);

  // R5
  idle_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cnt));

  // R5
  idle_acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !p_vld |=> $stable(acc));

  // R2
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(p_vld && p_last));

  // R2
  strobe_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(N - 1));

  generate
    if (N > 1) begin : g_multi
      // R2
      single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    end
  endgenerate

endmodule

bind sc_macc sc_macc_chk #(.N(ACC_N), .CW(CNT_W), .AW(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cnt       (grp_cnt),
  .p_vld     (prod_vld),
  .p_last    (prod_last),
  .acc       (acc_q),
  .out_valid (out_valid)
);

// File: tb/sim_sc_macc.sv
`timescale 1ns/1ps
module sim_sc_macc;

  localparam int N0   = 5;
  localparam int OW0  = 24;
  localparam int SH0  = 16 + 12 + 3 - OW0;
  localparam int NVEC = 20;

  // each entry: {a[15:0], b[11:0], valid}
  localparam logic [28:0] VEC [NVEC] = '{
    {16'd100,   12'd3,    1'b1},
    {16'hFF9C,  12'd7,    1'b1},
    {16'd5,     12'hFFF,  1'b0},
    {16'd1234,  12'd56,   1'b1},
    {16'h8000,  12'h800,  1'b1},
    {16'h0000,  12'h000,  1'b0},
    {16'h7FFF,  12'h7FF,  1'b1},
    {16'hFFFF,  12'd1,    1'b1},
    {16'd300,   12'h7FF,  1'b1},
    {16'd2,     12'd2,    1'b0},
    {16'h1000,  12'h100,  1'b1},
    {16'h8001,  12'h801,  1'b1},
    {16'd9,     12'd9,    1'b1},
    {16'd4,     12'd4,    1'b1},
    {16'hF000,  12'h123,  1'b1},
    {16'h0F0F,  12'hE00,  1'b1},
    {16'h7777,  12'h777,  1'b0},
    {16'd11,    12'hFF5,  1'b1},
    {16'hABCD,  12'h321,  1'b1},
    {16'd1,     12'd1,    1'b0}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_a = '0;
  logic signed [11:0] in_b = '0;
  logic               out_valid0, out_valid1;
  logic [OW0-1:0]     out_data0;
  logic [15:0]        out_data1;

  int nchk = 0, nfail = 0, cyc = 0, npulse = 0, pc_prev = 0, pc_last = 0;
  logic [OW0-1:0] last0;
  logic [15:0]    last1;
  bit    done = 0;
  string tag = "R9";

  always #4 clk = ~clk;

  sc_macc #(.A_W(16), .B_W(12), .ACC_N(N0), .OUT_W(OW0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid0), .out_data(out_data0));

  sc_macc #(.A_W(8), .B_W(8), .ACC_N(1), .OUT_W(16)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a($signed(in_a[7:0])), .in_b($signed(in_b[7:0])),
    .out_valid(out_valid1), .out_data(out_data1));

  // Independent reference: group sums per requirement, delayed to the strobe cycle
  logic   mv0 [3], mv1 [3];
  longint md0 [3], md1 [3];
  longint s0;
  int     c0;

  always @(posedge clk) begin
    if (rst) begin
      s0 = 0; c0 = 0;
      for (int k = 0; k < 3; k++) begin mv0[k] = 0; mv1[k] = 0; md0[k] = 0; md1[k] = 0; end
    end else begin
      for (int k = 2; k > 0; k--) begin
        mv0[k] = mv0[k-1]; md0[k] = md0[k-1];
        mv1[k] = mv1[k-1]; md1[k] = md1[k-1];
      end
      mv0[0] = 0; mv1[0] = 0;
      if (in_valid) begin
        s0 = ((c0 == 0) ? 64'sd0 : s0) + longint'(in_a) * longint'(in_b);
        c0++;
        if (c0 == N0) begin mv0[0] = 1; md0[0] = s0; c0 = 0; end
        mv1[0] = 1;
        md1[0] = longint'($signed(in_a[7:0])) * longint'($signed(in_b[7:0]));
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mv0[2] || out_valid0) begin
        logic [OW0-1:0] e0;
        e0 = md0[2][SH0 +: OW0];
        check(out_valid0 === mv0[2] && (!mv0[2] || out_data0 === e0),
              {tag, " R1 R2 R6 u0"}, {out_valid0, out_data0}, {mv0[2], e0});
      end
      if (mv1[2] || out_valid1) begin
        logic [15:0] e1;
        e1 = md1[2][15:0];
        check(out_valid1 === mv1[2] && (!mv1[2] || out_data1 === e1),
              "R8 u1", {out_valid1, out_data1}, {mv1[2], e1});
      end
      if (out_valid0) begin npulse++; pc_prev = pc_last; pc_last = cyc; last0 = out_data0; end
      if (out_valid1) last1 = out_data1;
    end
  end

  task automatic drv(input logic [15:0] a, input logic [11:0] b, input logic v);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = v;
  endtask

  task automatic do_rst();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R9: cleared state visible at the ports during reset
    check(out_valid0 == 0 && out_data0 == '0 && out_valid1 == 0, "R9 reset state",
          {out_valid0, out_data0}, 0);
    rst = 1'b0;
  endtask

  task automatic flush();
    repeat (5) drv(16'd0, 12'd0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R9: state straight out of reset
    repeat (2) @(negedge clk);
    check(out_valid0 == 0 && out_data0 == '0, "R9 initial reset", {out_valid0, out_data0}, 0);
    rst = 1'b0;

    // Table walk: mixed signs, gaps (R5), extremes, truncation (R6)
    tag = "R5 table";
    for (int i = 0; i < NVEC; i++) drv(VEC[i][28:13], VEC[i][12:1], VEC[i][0]);
    flush();

    // R4 / R3: back-to-back groups
    do_rst();
    tag = "R4 stream";
    npulse = 0;
    for (int i = 0; i < 2 * N0; i++) drv(16'd1000 + 16'(i), 12'd100, 1'b1);
    flush();
    check(npulse == 2, "R4 strobe count", npulse, 2);
    check(pc_last - pc_prev == N0, "R4 strobe spacing", pc_last - pc_prev, N0);
    check(last0 == OW0'((1005 + 1006 + 1007 + 1008 + 1009) * 100 >> SH0),
          "R3 second group starts at zero", last0,
          (1005 + 1006 + 1007 + 1008 + 1009) * 100 >> SH0);

    // R5: idle cycles with busy operands inside a group
    tag = "R5 idle";
    for (int i = 0; i < 3; i++) drv(16'd64, 12'd64, 1'b1);
    repeat (6) drv(16'h7FFF, 12'h7FF, 1'b0);
    for (int i = 0; i < 2; i++) drv(16'd64, 12'd64, 1'b1);
    flush();
    check(last0 == OW0'(5 * 4096 >> SH0), "R5 idle ignored", last0, 5 * 4096 >> SH0);

    // R7: worst-case operands, no overflow
    tag = "R7 extreme";
    for (int i = 0; i < N0; i++) drv(16'h8000, 12'h800, 1'b1);
    flush();
    check(last0 == 24'd2621440, "R7 min*min group", last0, 2621440);
    for (int i = 0; i < N0; i++) drv(16'h8000, 12'h7FF, 1'b1);
    flush();
    check(last0 == OW0'(-2620160), "R7 min*max group", last0, OW0'(-2620160));

    // R9: reset in the middle of a group discards the partial sum
    for (int i = 0; i < 3; i++) drv(16'h4000, 12'h400, 1'b1);
    do_rst();
    tag = "R9 after reset";
    npulse = 0;
    for (int i = 0; i < N0; i++) drv(16'd10, 12'd10, 1'b1);
    flush();
    check(npulse == 1 && last0 == 24'd3, "R9 partial group dropped", last0, 3);

    // R8: single-product groups
    drv(16'h00FD, 12'h005, 1'b1);
    flush();
    check(last1 == 16'hFFF1, "R8 single product", last1, 16'hFFF1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule